// File: doc/BRIEF.md
# Paged Flash Erase Sequencer

This block turns one erase request, a byte offset and a byte length, into a series of erase commands for a paged serial flash. It reaches the flash through a byte-wide command path: a transmit byte stream, a receive byte stream and a chip-select line that frames each transaction. The page size in bytes and the left shift that turns a page index into a device address are configuration inputs. They are sampled with the request, so one instance can drive parts with power-of-two pages and parts with odd page sizes such as 264 or 1056 bytes.

The block first divides the offset and the length by the page size. It rejects the request if either division leaves a remainder. Otherwise it walks through the pages. At each step it issues an eight-page block erase when the current page index is a multiple of eight and at least eight pages remain; in every other case it issues a single-page erase. After each command it polls the device status byte until the ready bit is set. Between polls it waits a programmable number of prescaled ticks. It gives up with a timeout once the accumulated waiting reaches a programmable limit.

Back-pressure rules for the streams:
- Request side: the request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle.
- Transmit side: once `tx_valid` rises, it and `tx_data` hold steady until a cycle with `tx_ready` high.
- Receive side: the block raises `rx_ready` only while it waits for a status byte. It takes the byte in the cycle where `rx_valid` is also high.

Top module: `erase_seq`

## Requirements
- R1: A request is accepted on a cycle with `req_valid` and `req_ready` both high. `req_ready` is high only in the idle state and drops in the cycle after an acceptance.
- R2: If the offset or the length is not a whole multiple of `page_bytes`, the block ends with `err_code` = 1 (misaligned) and opens no chip-select frame.
- R3: A zero length that is otherwise aligned ends with `err_code` = 0 and opens no frame.
- R4: The erase opcode is 0x50 (block of eight pages) when the page index is a multiple of 8 and at least 8 pages remain. Otherwise it is 0x81 (single page).
- R5: Each command frame is exactly four transmitted bytes, in this order: opcode, device address bits 23:16, device address bits 15:8, then 0x00. The device address is the page index shifted left by `page_shift`.
- R6: After a block erase the page index advances by 8; after a page erase it advances by 1. Every page of the request is erased exactly once and no other page is touched.
- R7: After every command the block runs status polls. Each poll is a frame carrying the single byte 0xD7, followed by one received byte. Only bit 7 of that byte matters: a 1 means ready, and the remaining bits are ignored.
- R8: Chip select (`cs_n`, active low) stays high for at least one cycle between frames. Each frame closes right after its last byte, so every command and every poll is framed on its own.
- R9: After a not-ready status, the next poll opcode is accepted POLL_TICKS × CLK_PER_TICK + 2 cycles after the status byte, plus any transmit stall. When the accumulated wait reaches TMO_TICKS ticks without a ready status, the block ends with `err_code` = 2 (timeout). That happens after ceil(TMO_TICKS / POLL_TICKS) polls of the last command.
- R10: `done` is a one-cycle strobe, one per accepted request. `err_code` is valid while `done` is high.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_offset | input | AW | Start byte offset |
| req_len | input | AW | Length in bytes |
| page_bytes | input | PW | Page size in bytes, nonzero; sampled with the request |
| page_shift | input | 4 | Page-index-to-address shift, 8 to 11; sampled with the request |
| cs_n | output | 1 | Flash chip select, active low |
| tx_valid | output | 1 | Transmit byte present |
| tx_ready | input | 1 | Shift engine takes the transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Block waits for a status byte |
| rx_data | input | 8 | Received status byte |
| done | output | 1 | One-cycle completion strobe |
| err_code | output | 2 | Result: 0 none, 1 misaligned, 2 timeout |

## Verification
A wrong page index or remaining count shows up in the very next command frame. It appears as the wrong opcode or as wrong address bytes, and it also changes the number of command frames before `done`. The bench therefore sweeps start pages and page counts around the eight-page boundaries and predicts each frame arithmetically. A fault in the poll or wait logic shows up as a wrong number of 0xD7 frames per command, or as a poll that comes early or late against the prescaled interval. A fault in the timeout counter moves the timeout to a different poll count.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
  localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
  localparam logic [7:0] OP_STATUS      = 8'hD7;
  localparam int         PAGES_PER_BLK  = 8;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_ALIGN   = 2'd1,
    ERR_TIMEOUT = 2'd2
  } err_t;

  typedef enum logic [3:0] {
    S_IDLE, S_DOFF, S_DLEN, S_CHK, S_CMD, S_CGAP,
    S_POP, S_PRX, S_PGAP, S_WAIT, S_ADV, S_FIN
  } state_t;
endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int CLK_PER_TICK = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (restart || cnt == LAST)  cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST) && !restart;

  generate
    if (CLK_PER_TICK > 1) begin : g_chk
      assert_tick_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/serial_div.sv
module serial_div #(
  parameter int W  = 24,
  parameter int DW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [W-1:0]  quo,
  output logic [DW-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic          run;
  logic [CW-1:0] cnt;
  logic [W-1:0]  q_r;
  logic [DW-1:0] r_r;
  logic [DW:0]   trial;
  logic          take;

  assign trial = {r_r, q_r[W-1]};
  assign take  = trial >= {1'b0, den};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; cnt <= '0; q_r <= '0; r_r <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run <= 1'b1; cnt <= '0; q_r <= num; r_r <= '0;
      end else if (run) begin
        q_r <= {q_r[W-2:0], take};
        r_r <= take ? DW'(trial - {1'b0, den}) : trial[DW-1:0];
        cnt <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quo = q_r;
  assign rem = r_r;

  assert_rem_below_den_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && (den != '0) |-> rem < den);
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_seq_pkg::*;
#(
  parameter int AW           = 24,
  parameter int PW           = 11,
  parameter int CLK_PER_TICK = 1000,
  parameter int POLL_TICKS   = 3,
  parameter int TMO_TICKS    = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_offset,
  input  logic [AW-1:0] req_len,
  input  logic [PW-1:0] page_bytes,
  input  logic [3:0]    page_shift,
  output logic          cs_n,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  output logic          done,
  output logic [1:0]    err_code
);
  localparam int WCW = $clog2(POLL_TICKS + 1);
  localparam int TCW = $clog2(TMO_TICKS + 1);
  localparam logic [AW-1:0] BLK_PAGES = AW'(PAGES_PER_BLK);

  state_t        state;
  err_t          err_q;
  logic [AW-1:0] len_q, idx_q, pages_q;
  logic [PW-1:0] page_q;
  logic [3:0]    shift_q;
  logic          blk_q, off_bad_q;
  logic [1:0]    byte_q;
  logic [7:0]    status_q;
  logic [WCW-1:0] wait_q;
  logic [TCW-1:0] tmo_q;

  logic          req_fire, div_start, div_done, tick, restart;
  logic [AW-1:0] div_num, div_quo;
  logic [PW-1:0] div_rem;
  logic [AW+15:0] addr_wide;

  assign req_ready = (state == S_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign div_start = req_fire || (state == S_DOFF && div_done);
  assign div_num   = (state == S_IDLE) ? req_offset : len_q;
  assign restart   = (state == S_PGAP);
  assign addr_wide = {16'b0, idx_q} << shift_q;

  serial_div #(.W(AW), .DW(PW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num),
    .den(req_fire ? page_bytes : page_q),
    .done(div_done), .quo(div_quo), .rem(div_rem)
  );

  tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
  );

  always_comb begin
    tx_data = 8'h00;
    if (state == S_POP) tx_data = OP_STATUS;
    else begin
      case (byte_q)
        2'd0:    tx_data = blk_q ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
        2'd1:    tx_data = addr_wide[23:16];
        2'd2:    tx_data = addr_wide[15:8];
        default: tx_data = 8'h00;
      endcase
    end
  end

  assign tx_valid = (state == S_CMD) || (state == S_POP);
  assign rx_ready = (state == S_PRX);
  assign cs_n     = !((state == S_CMD) || (state == S_POP) || (state == S_PRX));
  assign done     = (state == S_FIN);
  assign err_code = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; err_q <= ERR_NONE; len_q <= '0; idx_q <= '0;
      pages_q <= '0; page_q <= '0; shift_q <= '0; blk_q <= 1'b0;
      off_bad_q <= 1'b0; byte_q <= '0; status_q <= '0; wait_q <= '0; tmo_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_fire) begin
          len_q <= req_len; page_q <= page_bytes; shift_q <= page_shift;
          state <= S_DOFF;
        end
        S_DOFF: if (div_done) begin
          idx_q <= div_quo; off_bad_q <= (div_rem != '0); state <= S_DLEN;
        end
        S_DLEN: if (div_done) begin
          pages_q <= div_quo;
          if (off_bad_q || div_rem != '0) begin
            err_q <= ERR_ALIGN; state <= S_FIN;
          end else state <= S_CHK;
        end
        S_CHK: begin
          if (pages_q == '0) begin
            err_q <= ERR_NONE; state <= S_FIN;
          end else begin
            blk_q  <= (idx_q[2:0] == 3'd0) && (pages_q >= BLK_PAGES);
            byte_q <= '0; tmo_q <= '0; state <= S_CMD;
          end
        end
        S_CMD: if (tx_ready) begin
          byte_q <= byte_q + 1'b1;
          if (byte_q == 2'd3) state <= S_CGAP;
        end
        S_CGAP: state <= S_POP;
        S_POP:  if (tx_ready) state <= S_PRX;
        S_PRX:  if (rx_valid) begin
          status_q <= rx_data; state <= S_PGAP;
        end
        S_PGAP: begin
          wait_q <= '0;
          state  <= status_q[7] ? S_ADV : S_WAIT;
        end
        S_WAIT: if (tick) begin
          wait_q <= wait_q + 1'b1;
          tmo_q  <= tmo_q + 1'b1;
          if (wait_q == WCW'(POLL_TICKS - 1)) begin
            if (tmo_q + 1'b1 >= TCW'(TMO_TICKS)) begin
              err_q <= ERR_TIMEOUT; state <= S_FIN;
            end else state <= S_POP;
          end
        end
        S_ADV: begin
          idx_q   <= idx_q + (blk_q ? BLK_PAGES : AW'(1));
          pages_q <= pages_q - (blk_q ? BLK_PAGES : AW'(1));
          state   <= S_CHK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_accept_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  assert_poll_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready |=> cs_n);
endmodule

// File: tb/sim_erase_seq.sv
module sim_erase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int PW = 11;
  localparam int CPT = 4;
  localparam int POLLT = 3;
  localparam int TMOT = 40;
  localparam int IVAL = POLLT * CPT + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_offset = '0, req_len = '0;
  logic [PW-1:0] page_bytes = 11'd264;
  logic [3:0] page_shift = 4'd9;
  logic cs_n, tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready, done;
  logic [7:0] tx_data, rx_data = 8'h00;
  logic [1:0] err_code;

  erase_seq #(.AW(AW), .PW(PW), .CLK_PER_TICK(CPT), .POLL_TICKS(POLLT), .TMO_TICKS(TMOT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_len(req_len), .page_bytes(page_bytes),
    .page_shift(page_shift), .cs_n(cs_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .done(done), .err_code(err_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  int cyc = 0, busy_cfg = 0, busy_left = 0;
  int ncmd = 0, npoll = 0, nbad = 0, done_cnt = 0, done_err = 0;
  logic [7:0] cmd_b [0:63][0:3];
  logic [7:0] fb [0:7];
  int flen = 0, t_busy = 0;
  bit int_pending = 0, rx_drop = 0, prev_cs = 1'b1;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // device model and monitor, all at the falling edge
  initial forever begin
    @(negedge clk);
    cyc++;
    if (!prev_cs && cs_n) begin
      if (flen == 4 && fb[0] != 8'hD7) begin
        if (ncmd < 64) for (int i = 0; i < 4; i++) cmd_b[ncmd][i] = fb[i];
        ncmd++;
        busy_left = busy_cfg;
      end else if (flen == 1 && fb[0] == 8'hD7) npoll++;
      else nbad++;
      flen = 0;
    end
    prev_cs = cs_n;
    if (done) begin done_cnt++; done_err = err_code; end
    tx_ready = (cyc % 3) != 1;
    if (rx_drop) begin rx_valid = 1'b0; rx_drop = 0; end
    if (rx_ready && !rx_valid) begin
      rx_valid = 1'b1;
      rx_data  = (busy_left > 0) ? 8'h7F : 8'hBC;
    end
    if (tx_valid && tx_ready) begin
      if (flen < 8) fb[flen] = tx_data;
      flen++;
      if (flen == 1 && tx_data == 8'hD7 && int_pending) begin
        chk((cyc - t_busy) >= IVAL && (cyc - t_busy) <= IVAL + 1, "R9 poll interval",
            cyc - t_busy, IVAL);
        int_pending = 0;
      end
    end
    if (rx_valid && rx_ready) begin
      if (busy_left > 0) begin busy_left--; t_busy = cyc; int_pending = 1; end
      rx_drop = 1;
    end
  end

  task automatic do_req(input int off, input int len, input int pb, input int sh, input int busy);
    busy_cfg = busy; ncmd = 0; npoll = 0; nbad = 0; done_cnt = 0; int_pending = 0;
    page_bytes = PW'(pb); page_shift = 4'(sh);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_offset = AW'(off); req_len = AW'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 busy after accept", req_ready, 0);
    while (done_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R10 single done strobe", done_cnt, 1);
    chk(nbad == 0, "R8 frame shape", nbad, 0);
  endtask

  task automatic verify_seq(input int start, input int np, input int sh, input int busy);
    int idx = start, n = np, k = 0, bad = 0;
    logic [31:0] a;
    logic [7:0] op;
    while (n > 0) begin
      bit blk = (idx % 8 == 0) && (n >= 8);
      op = blk ? 8'h50 : 8'h81;          // R4
      a = 32'(idx) << sh;                // R5
      if (k < 64) begin
        if (cmd_b[k][0] != op || cmd_b[k][1] != a[23:16] || cmd_b[k][2] != a[15:8] ||
            cmd_b[k][3] != 8'h00) begin
          bad++;
          $display("FAIL R4/R5 cmd %0d actual=%h%h%h%h expected=%h%h%h00", k,
                   cmd_b[k][0], cmd_b[k][1], cmd_b[k][2], cmd_b[k][3], op, a[23:16], a[15:8]);
        end
      end
      idx += blk ? 8 : 1;                // R6
      n   -= blk ? 8 : 1;
      k++;
    end
    checks++; if (bad != 0) fails++;
    chk(ncmd == k, "R6 command count", ncmd, k);
    chk(npoll == k * (busy + 1), "R7 polls per command", npoll, k * (busy + 1));
    chk(done_err == 0, "R10 no error", done_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1 && tx_valid == 1'b0 && rx_ready == 1'b0, "R8 reset idle bus", cs_n, 1);
    chk(req_ready == 1'b1 && done == 1'b0, "R1 reset ready", req_ready, 1);

    do_req(100, 264, 264, 9, 0);
    chk(done_err == 1, "R2 offset misaligned", done_err, 1);
    chk(ncmd + npoll == 0, "R2 no frames", ncmd + npoll, 0);
    do_req(264, 200, 264, 9, 0);
    chk(done_err == 1, "R2 length misaligned", done_err, 1);
    chk(ncmd + npoll == 0, "R2 no frames len", ncmd + npoll, 0);
    do_req(528, 0, 264, 9, 0);
    chk(done_err == 0, "R3 zero length", done_err, 0);
    chk(ncmd + npoll == 0, "R3 no frames", ncmd + npoll, 0);

    for (int cfg = 0; cfg < 2; cfg++) begin
      int pb = (cfg == 0) ? 264 : 256;
      int sh = (cfg == 0) ? 9 : 8;
      for (int s = 0; s < 10; s++) begin
        for (int j = 0; j < 7; j++) begin
          int np = (j == 0) ? 1 : (j == 1) ? 3 : (j == 2) ? 7 : (j == 3) ? 8 :
                   (j == 4) ? 9 : (j == 5) ? 16 : 17;
          do_req(s * pb, np * pb, pb, sh, s % 3);
          verify_seq(s, np, sh, s % 3);
        end
      end
    end

    do_req(5000 * 1056, 3 * 1056, 1056, 11, 1);
    verify_seq(5000, 3, 11, 1);
    do_req(4096 * 1056, 9 * 1056, 1056, 11, 0);
    verify_seq(4096, 9, 11, 0);

    do_req(8 * 264, 16 * 264, 264, 9, 1000);
    chk(done_err == 2, "R9 timeout code", done_err, 2);
    chk(ncmd == 1, "R9 stops after first command", ncmd, 1);
    chk(npoll == (TMOT + POLLT - 1) / POLLT, "R9 polls before timeout", npoll,
        (TMOT + POLLT - 1) / POLLT);

    do_req(0, 264, 264, 9, 0);
    verify_seq(0, 1, 9, 0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule